// File: doc/BRIEF.md
# I2C Bus Condition Monitor and Open-Drain Line Driver

This block sits between a pair of open-drain I2C pads and the byte-level engine of an I2C controller. It synchronizes the raw SDA and SCL lines and watches them for the three framing events: a start, a stop, and a repeated start. It keeps a bus-busy flag. When a stop is seen, or when the slave side reports that the address did not match, it sends a one-cycle cancel pulse. That pulse aborts the transfer and resets the external clock generator.

On the output side, the block decides when each line is pulled low. Data and acknowledge bits are latched only on a strobe that marks the middle of the SCL low phase. Master framing commands (start, stop, restart) bypass that rule and act at once. In master mode the block watches for lost arbitration and releases SDA once it has lost. SCL follows the internal clock while the block owns the bus, during framing commands and after a loss. Both outputs are active-high drive-low enables, so the block never drives a line high.

Top module: `i2c_line_ctrl`

## Requirements
- R1: When the bus is idle, SDA falling while SCL is high (after synchronization) raises `start_o` for exactly one cycle. `rstart_o` stays low.
- R2: SDA rising while SCL is high raises `stop_o` for one cycle. `busy_o` clears on the following cycle.
- R3: A start sets `busy_o` on the cycle after `start_o`. A start seen while `busy_o` is set raises `rstart_o` instead of `start_o`, and `busy_o` stays set.
- R4: `cancel_o` pulses for one cycle on the cycle after a detected stop, or on the cycle after `addr_miss_i` is high. The pulse releases any held data or acknowledge drive on SDA.
- R5: With `cmd_i` = 00 (no command), `sda_oe_o` changes only after a clock edge where `mid_low_i` is high, or on a cancel. At that edge it takes the requested drive value, and between strobes it holds.
- R6: In master mode (`master_i`=1) the requested drive is low for a transmitted 0 bit (`tx_en_i`=1, `tx_bit_i`=0) or for an acknowledge (`ack_en_i`=1). `addr_ack_i` has no effect in master mode.
- R7: In slave mode the requested drive is low for `addr_ack_i`, for a transmitted 0 bit, or for `ack_en_i`.
- R8: In master mode, without lost arbitration, `cmd_i` acts in the same cycle. 01 (start) and 10 (stop) pull SDA low. 11 (restart) makes `sda_oe_o` equal `scl_int_i`, so SDA is released while the internal clock is low and pulled low while it is high.
- R9: In master mode, `scl_oe_o` equals the inverse of `scl_int_i` while `busy_o` is set, while arbitration is lost, or while a command is active. Otherwise it is 0. In slave mode `scl_oe_o` is always 0.
- R10: In master mode with `busy_o` set, if SDA reads low while SCL is high and the block was releasing SDA, `arb_lost_o` sets. It stays set until a stop, and while it is set `sda_oe_o` is 0.
- R11: After reset, `sda_oe_o`, `scl_oe_o`, `busy_o`, `arb_lost_o` and all event pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | Raw SDA line level |
| scl_i | input | 1 | Raw SCL line level |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| mid_low_i | input | 1 | Strobe at the middle of the SCL low phase |
| tx_en_i | input | 1 | A data bit is being transmitted |
| tx_bit_i | input | 1 | Data bit value to transmit |
| ack_en_i | input | 1 | Give an acknowledge on receive |
| addr_ack_i | input | 1 | Slave acknowledges its matched address |
| addr_miss_i | input | 1 | Slave address mismatch |
| cmd_i | input | 2 | Framing command: 00 none, 01 start, 10 stop, 11 restart |
| scl_int_i | input | 1 | Internal SCL from the clock generator |
| sda_oe_o | output | 1 | Pull SDA low |
| scl_oe_o | output | 1 | Pull SCL low |
| start_o | output | 1 | Start detected (bus was idle) |
| rstart_o | output | 1 | Repeated start detected |
| stop_o | output | 1 | Stop detected |
| busy_o | output | 1 | Bus busy |
| cancel_o | output | 1 | Cancel pulse; resets the clock generator |
| arb_lost_o | output | 1 | Arbitration lost |

## Verification
The hardest state to reach from the ports is lost arbitration. It needs the block to own the bus as master, to have released SDA, and then to see another device hold SDA low across a rising SCL, all without producing a false start or stop on the way. The bench models the open-drain wires by ANDing each driver output with an external pull-down. It issues its own start command, lowers the internal clock before releasing SDA, pulls SDA low externally while SCL is still low, and only then raises the internal clock.

// File: rtl/i2c_line_pkg.sv
package i2c_line_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'b00,
    CMD_START   = 2'b01,
    CMD_STOP    = 2'b10,
    CMD_RESTART = 2'b11
  } seq_cmd_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  // idle bus reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '1;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_s_i,
  input  logic scl_s_i,
  input  logic addr_miss_i,
  output logic start_o,
  output logic rstart_o,
  output logic stop_o,
  output logic busy_o,
  output logic cancel_o
);
  logic sda_q, busy_q, cancel_q;
  logic start_raw, stop_raw;

  assign start_raw = sda_q & ~sda_s_i & scl_s_i;
  assign stop_raw  = ~sda_q & sda_s_i & scl_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q    <= 1'b1;
      busy_q   <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      sda_q    <= sda_s_i;
      cancel_q <= stop_raw | addr_miss_i;
      if (stop_raw)       busy_q <= 1'b0;
      else if (start_raw) busy_q <= 1'b1;
    end
  end

  assign start_o  = start_raw & ~busy_q;
  assign rstart_o = start_raw & busy_q;
  assign stop_o   = stop_raw;
  assign busy_o   = busy_q;
  assign cancel_o = cancel_q;

  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_raw |=> busy_q);
  p_stop_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_raw |=> !busy_q);
  p_cancel_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_raw || addr_miss_i) |=> cancel_q);
endmodule

// File: rtl/i2c_drive_ctrl.sv
module i2c_drive_ctrl
  import i2c_line_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     master_i,
  input  logic     mid_low_i,
  input  logic     tx_en_i,
  input  logic     tx_bit_i,
  input  logic     ack_en_i,
  input  logic     addr_ack_i,
  input  seq_cmd_e cmd_i,
  input  logic     scl_int_i,
  input  logic     sda_s_i,
  input  logic     scl_s_i,
  input  logic     busy_i,
  input  logic     stop_i,
  input  logic     cancel_i,
  output logic     sda_oe_o,
  output logic     scl_oe_o,
  output logic     arb_lost_o
);
  logic                   sda_hold_q, arb_lost_q, want_low, sda_oe;
  logic [SYNC_STAGES-1:0] oe_dly_q;

  assign want_low = (tx_en_i & ~tx_bit_i) | ack_en_i | (~master_i & addr_ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_hold_q <= 1'b0;
    end else if (cancel_i) begin
      sda_hold_q <= 1'b0;
    end else if (mid_low_i) begin
      sda_hold_q <= want_low;
    end
  end

  always_comb begin
    if (master_i && arb_lost_q) begin
      sda_oe = 1'b0;
    end else if (master_i && cmd_i != CMD_NONE) begin
      unique case (cmd_i)
        CMD_RESTART: sda_oe = scl_int_i;
        default:     sda_oe = 1'b1;
      endcase
    end else begin
      sda_oe = sda_hold_q;
    end
  end

  // align own drive with the synchronized line sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_dly_q <= '0;
    else         oe_dly_q <= {oe_dly_q[SYNC_STAGES-2:0], sda_oe};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arb_lost_q <= 1'b0;
    end else if (stop_i) begin
      arb_lost_q <= 1'b0;
    end else if (master_i && busy_i && !oe_dly_q[SYNC_STAGES-1] && scl_s_i && !sda_s_i) begin
      arb_lost_q <= 1'b1;
    end
  end

  assign sda_oe_o   = sda_oe;
  assign scl_oe_o   = master_i & (busy_i | arb_lost_q | (cmd_i != CMD_NONE)) & ~scl_int_i;
  assign arb_lost_o = arb_lost_q;

  p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mid_low_i && !cancel_i) |=> $stable(sda_hold_q));
  p_arb_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_q && !stop_i) |=> arb_lost_q);
endmodule

// File: rtl/i2c_line_ctrl.sv
module i2c_line_ctrl
  import i2c_line_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_i,
  input  logic       master_i,
  input  logic       mid_low_i,
  input  logic       tx_en_i,
  input  logic       tx_bit_i,
  input  logic       ack_en_i,
  input  logic       addr_ack_i,
  input  logic       addr_miss_i,
  input  logic [1:0] cmd_i,
  input  logic       scl_int_i,
  output logic       sda_oe_o,
  output logic       scl_oe_o,
  output logic       start_o,
  output logic       rstart_o,
  output logic       stop_o,
  output logic       busy_o,
  output logic       cancel_o,
  output logic       arb_lost_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_s;
  logic             sda_s, scl_s;
  seq_cmd_e         cmd;

  assign cmd = seq_cmd_e'(cmd_i);

  i2c_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign sda_s = line_s[0];
  assign scl_s = line_s[1];

  i2c_cond_detect u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_s_i    (scl_s),
    .addr_miss_i(addr_miss_i),
    .start_o    (start_o),
    .rstart_o   (rstart_o),
    .stop_o     (stop_o),
    .busy_o     (busy_o),
    .cancel_o   (cancel_o)
  );

  i2c_drive_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .master_i  (master_i),
    .mid_low_i (mid_low_i),
    .tx_en_i   (tx_en_i),
    .tx_bit_i  (tx_bit_i),
    .ack_en_i  (ack_en_i),
    .addr_ack_i(addr_ack_i),
    .cmd_i     (cmd),
    .scl_int_i (scl_int_i),
    .sda_s_i   (sda_s),
    .scl_s_i   (scl_s),
    .busy_i    (busy_o),
    .stop_i    (stop_o),
    .cancel_i  (cancel_o),
    .sda_oe_o  (sda_oe_o),
    .scl_oe_o  (scl_oe_o),
    .arb_lost_o(arb_lost_o)
  );

  p_start_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !arb_lost_o && cmd == CMD_START) |-> sda_oe_o);
  p_slave_scl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !scl_oe_o);
  p_event_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
endmodule

// File: tb/tb_i2c_line_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_line_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master_i = 1'b0, mid_low_i = 1'b0, tx_en_i = 1'b0, tx_bit_i = 1'b1;
  logic ack_en_i = 1'b0, addr_ack_i = 1'b0, addr_miss_i = 1'b0, scl_int_i = 1'b1;
  logic [1:0] cmd_i = 2'b00;
  logic ext_sda_low = 1'b0, ext_scl_low = 1'b0;
  logic sda_oe_o, scl_oe_o, start_o, rstart_o, stop_o, busy_o, cancel_o, arb_lost_o;
  logic sda_line, scl_line;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = ~(sda_oe_o | ext_sda_low);
  assign scl_line = ~(scl_oe_o | ext_scl_low);

  i2c_line_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .sda_i(sda_line), .scl_i(scl_line),
    .master_i(master_i), .mid_low_i(mid_low_i), .tx_en_i(tx_en_i), .tx_bit_i(tx_bit_i),
    .ack_en_i(ack_en_i), .addr_ack_i(addr_ack_i), .addr_miss_i(addr_miss_i),
    .cmd_i(cmd_i), .scl_int_i(scl_int_i),
    .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o), .start_o(start_o), .rstart_o(rstart_o),
    .stop_o(stop_o), .busy_o(busy_o), .cancel_o(cancel_o), .arb_lost_o(arb_lost_o)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe();
    mid_low_i = 1'b1;
    wait_n(1);
    mid_low_i = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R11 sda_oe", sda_oe_o, 1'b0);
    chk("R11 scl_oe", scl_oe_o, 1'b0);
    chk("R11 busy", busy_o, 1'b0);
    chk("R11 arb_lost", arb_lost_o, 1'b0);
    chk("R11 start", start_o, 1'b0);
    chk("R11 cancel", cancel_o, 1'b0);
  endtask

  task automatic t_start_rstart();
    master_i = 1'b0;
    ext_sda_low = 1'b1;
    wait_n(2);
    chk("R1 start pulse", start_o, 1'b1);
    chk("R1 no rstart", rstart_o, 1'b0);
    wait_n(1);
    chk("R1 start one cycle", start_o, 1'b0);
    chk("R3 busy set", busy_o, 1'b1);
    ext_scl_low = 1'b1; wait_n(3);
    ext_sda_low = 1'b0; wait_n(3);
    ext_scl_low = 1'b0; wait_n(3);
    ext_sda_low = 1'b1;
    wait_n(2);
    chk("R3 rstart pulse", rstart_o, 1'b1);
    chk("R3 no plain start", start_o, 1'b0);
    wait_n(1);
    chk("R3 busy kept", busy_o, 1'b1);
  endtask

  task automatic t_stop();
    ext_scl_low = 1'b1; wait_n(3);
    ext_scl_low = 1'b0; wait_n(3);
    ext_sda_low = 1'b0;
    wait_n(2);
    chk("R2 stop pulse", stop_o, 1'b1);
    wait_n(1);
    chk("R2 busy cleared", busy_o, 1'b0);
    chk("R4 cancel after stop", cancel_o, 1'b1);
    wait_n(1);
    chk("R4 cancel one cycle", cancel_o, 1'b0);
  endtask

  task automatic t_slave_miss();
    master_i = 1'b0;
    ext_scl_low = 1'b1; wait_n(3);
    addr_ack_i = 1'b1;
    strobe();
    addr_ack_i = 1'b0;
    chk("R7 addr ack drives", sda_oe_o, 1'b1);
    wait_n(2);
    chk("R5 hold between strobes", sda_oe_o, 1'b1);
    addr_miss_i = 1'b1;
    wait_n(1);
    addr_miss_i = 1'b0;
    chk("R4 cancel on miss", cancel_o, 1'b1);
    wait_n(1);
    chk("R4 cancel releases sda", sda_oe_o, 1'b0);
    chk("R2 miss leaves busy", busy_o, 1'b0);
  endtask

  task automatic t_master_bits();
    master_i = 1'b1;
    tx_en_i = 1'b1; tx_bit_i = 1'b0;
    wait_n(2);
    chk("R5 no change without strobe", sda_oe_o, 1'b0);
    strobe();
    chk("R6 tx zero drives", sda_oe_o, 1'b1);
    tx_bit_i = 1'b1;
    wait_n(2);
    chk("R5 holds until strobe", sda_oe_o, 1'b1);
    strobe();
    chk("R6 tx one releases", sda_oe_o, 1'b0);
    tx_en_i = 1'b0; ack_en_i = 1'b1;
    strobe();
    chk("R6 ack drives", sda_oe_o, 1'b1);
    ack_en_i = 1'b0; addr_ack_i = 1'b1;
    strobe();
    chk("R6 addr ack ignored in master", sda_oe_o, 1'b0);
    addr_ack_i = 1'b0;
  endtask

  task automatic t_slave_bits();
    master_i = 1'b0;
    tx_en_i = 1'b1; tx_bit_i = 1'b0;
    strobe();
    chk("R7 slave tx zero", sda_oe_o, 1'b1);
    tx_en_i = 1'b0; tx_bit_i = 1'b1; ack_en_i = 1'b1;
    strobe();
    chk("R7 slave ack", sda_oe_o, 1'b1);
    ack_en_i = 1'b0;
    strobe();
    chk("R7 slave release", sda_oe_o, 1'b0);
    scl_int_i = 1'b0; #1;
    chk("R9 slave never drives scl", scl_oe_o, 1'b0);
    scl_int_i = 1'b1;
    ext_scl_low = 1'b0;
    wait_n(3);
  endtask

  task automatic t_commands();
    master_i = 1'b1;
    cmd_i = 2'b01; #1;
    chk("R8 start cmd pulls sda", sda_oe_o, 1'b1);
    chk("R9 scl follows int high", scl_oe_o, 1'b0);
    wait_n(3);
    chk("R3 own start busy", busy_o, 1'b1);
    scl_int_i = 1'b0; #1;
    chk("R9 scl follows int low", scl_oe_o, 1'b1);
    wait_n(1);
    cmd_i = 2'b00; #1;
    chk("R9 owner drives scl", scl_oe_o, 1'b1);
    chk("R5 no cmd uses hold", sda_oe_o, 1'b0);
    wait_n(3);
    cmd_i = 2'b11; #1;
    chk("R8 restart releases at int low", sda_oe_o, 1'b0);
    wait_n(3);
    scl_int_i = 1'b1; #1;
    chk("R8 restart pulls at int high", sda_oe_o, 1'b1);
    wait_n(3);
    chk("R10 no loss on own restart", arb_lost_o, 1'b0);
    cmd_i = 2'b10; scl_int_i = 1'b0; #1;
    chk("R8 stop cmd pulls sda", sda_oe_o, 1'b1);
    wait_n(3);
    scl_int_i = 1'b1; wait_n(3);
    cmd_i = 2'b00;
    wait_n(4);
    chk("R2 own stop idles bus", busy_o, 1'b0);
    scl_int_i = 1'b0; #1;
    chk("R9 idle master leaves scl", scl_oe_o, 1'b0);
    scl_int_i = 1'b1;
    wait_n(3);
  endtask

  task automatic t_arbitration();
    master_i = 1'b1;
    cmd_i = 2'b01; wait_n(3);
    scl_int_i = 1'b0; cmd_i = 2'b00; wait_n(3);
    ext_sda_low = 1'b1; wait_n(3);
    chk("R10 no loss while scl low", arb_lost_o, 1'b0);
    scl_int_i = 1'b1;
    wait_n(4);
    chk("R10 loss flagged", arb_lost_o, 1'b1);
    ack_en_i = 1'b1;
    strobe();
    ack_en_i = 1'b0;
    chk("R10 sda released after loss", sda_oe_o, 1'b0);
    scl_int_i = 1'b0; #1;
    chk("R9 scl follows after loss", scl_oe_o, 1'b1);
    wait_n(3);
    scl_int_i = 1'b1; wait_n(3);
    ext_sda_low = 1'b0;
    wait_n(4);
    chk("R10 stop clears loss", arb_lost_o, 1'b0);
    chk("R2 busy clear after stop", busy_o, 1'b0);
  endtask

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(1);
    t_reset();
    t_start_rstart();
    t_stop();
    t_slave_miss();
    t_master_bits();
    t_slave_bits();
    t_commands();
    t_arbitration();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule